// File: doc/BRIEF.md
# Two-Priority Coherence Message Channel

This block is the receiving end of one source-to-destination link in a cache coherence fabric. Responses and requests arrive over the same wires, each beat carrying a one-bit class tag. The block sorts every accepted beat into one of two queues, one for responses and one for requests. It then offers a single output stream to the protocol engine behind it. A response is always served ahead of a request, so a request can never hold up a response. Within each class, the order of arrival is kept.

The input is a valid/ready stream with one ready per class. The sender must look at the ready of the class it is offering. A full request queue therefore stalls only request traffic, and responses keep flowing. The response queue is sized for the largest number of responses that can be in flight, and the sender never offers a response while `in_ready_rsp` is low.

The output is also valid/ready. A beat leaves on a rising edge where `out_valid` and `out_ready` are both high. A response on the output stays there, unchanged, until it is taken. A request that is waiting on the output can be replaced by a response that arrives later, because the response has priority.

Top module: `prio_msg_link`

## Requirements
- R1: After reset, `out_valid` is 0 and both `in_ready_rsp` and `in_ready_req` are 1.
- R2: Class tag encoding: `in_class`=1 marks a response and `in_class`=0 marks a request. Each beat comes out with the same tag on `out_class`, together with its own `out_addr` and `out_data`.
- R3: `out_valid` with `out_class`=0 occurs only when no response is held. Whenever a response is held, the output presents a response.
- R4: Within each class, beats leave in the order they were accepted. A request never leaves before a response to the same address that was accepted earlier.
- R5: When `REQ_DEPTH` requests are held, `in_ready_req` is 0, while `in_ready_rsp` stays 1 and a response is still accepted.
- R6: When `RSP_DEPTH` responses are held, `in_ready_rsp` is 0. The sender never offers a response while `in_ready_rsp` is 0.
- R7: A beat accepted on a rising edge is reflected on the output from that edge onward: `out_valid` is 1 in the following cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 in the next cycle. A response being presented keeps its tag, address and data unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sender has a beat on the link |
| in_class | input | 1 | 1 = response, 0 = request |
| in_addr | input | ADDR_W | Line address of the beat |
| in_data | input | DATA_W | Payload of the beat |
| in_ready_rsp | output | 1 | A response beat would be accepted |
| in_ready_req | output | 1 | A request beat would be accepted |
| out_valid | output | 1 | A beat is presented to the consumer |
| out_class | output | 1 | Class of the presented beat |
| out_addr | output | ADDR_W | Address of the presented beat |
| out_data | output | DATA_W | Payload of the presented beat |
| out_ready | input | 1 | Consumer takes the presented beat |

## Verification
The output is driven straight from the queue heads. A beat accepted on an edge is therefore due on the output in the very next cycle, and a beat taken on an edge is gone in the cycle after it. The bench does all of its work at the falling edge. It first compares the registered outputs with the heads of its two expected-order queues, and only then drives new inputs. It pushes a beat into its expected queue on the same falling edge where it finds the matching ready high. In this way the bench model and the design always move on the same rising edge.

// File: rtl/plink_pkg.sv
package plink_pkg;
  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_RSP = 1'b1
  } msg_class_e;

  localparam int NUM_CLASSES = 2;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;
  logic             do_push, do_pop;

  assign empty     = (used == '0);
  assign full      = (used == FULL_CNT);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_data = slots[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/class_steer.sv
module class_steer
  import plink_pkg::*;
(
  input  logic in_valid,
  input  logic in_class,
  input  logic rsp_full,
  input  logic req_full,
  output logic in_ready_rsp,
  output logic in_ready_req,
  output logic push_rsp,
  output logic push_req
);
  logic is_rsp;

  assign is_rsp       = (msg_class_e'(in_class) == CLS_RSP);
  assign in_ready_rsp = !rsp_full;
  assign in_ready_req = !req_full;
  assign push_rsp     = in_valid && is_rsp && !rsp_full;
  assign push_req     = in_valid && !is_rsp && !req_full;
endmodule

// File: rtl/head_select.sv
module head_select
  import plink_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             rsp_empty,
  input  logic             req_empty,
  input  logic [WIDTH-1:0] rsp_head,
  input  logic [WIDTH-1:0] req_head,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_class,
  output logic [WIDTH-1:0] out_msg,
  output logic             pop_rsp,
  output logic             pop_req
);
  logic pick_rsp;

  always_comb begin
    pick_rsp  = !rsp_empty;
    out_valid = !rsp_empty || !req_empty;
    out_class = pick_rsp ? logic'(CLS_RSP) : logic'(CLS_REQ);
    out_msg   = pick_rsp ? rsp_head : req_head;
    pop_rsp   = out_ready && pick_rsp;
    pop_req   = out_ready && !pick_rsp && !req_empty;
  end
endmodule

// File: rtl/prio_msg_link.sv
module prio_msg_link
  import plink_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int RSP_DEPTH = 4,
  parameter int REQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_class,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready_rsp,
  output logic              in_ready_req,
  output logic              out_valid,
  output logic              out_class,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int MSG_W = ADDR_W + DATA_W;

  logic [MSG_W-1:0] in_msg, out_msg;
  logic [NUM_CLASSES-1:0] q_push, q_pop, q_empty, q_full;
  logic [MSG_W-1:0] q_head [NUM_CLASSES];

  assign in_msg = {in_addr, in_data};

  class_steer u_steer (
    .in_valid    (in_valid),
    .in_class    (in_class),
    .rsp_full    (q_full[CLS_RSP]),
    .req_full    (q_full[CLS_REQ]),
    .in_ready_rsp(in_ready_rsp),
    .in_ready_req(in_ready_req),
    .push_rsp    (q_push[CLS_RSP]),
    .push_req    (q_push[CLS_REQ])
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_queue
    localparam int QD = (c == int'(CLS_RSP)) ? RSP_DEPTH : REQ_DEPTH;
    msg_fifo #(
      .WIDTH(MSG_W),
      .DEPTH(QD)
    ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push[c]),
      .push_data(in_msg),
      .pop      (q_pop[c]),
      .head_data(q_head[c]),
      .empty    (q_empty[c]),
      .full     (q_full[c])
    );
  end

  head_select #(
    .WIDTH(MSG_W)
  ) u_select (
    .rsp_empty(q_empty[CLS_RSP]),
    .req_empty(q_empty[CLS_REQ]),
    .rsp_head (q_head[CLS_RSP]),
    .req_head (q_head[CLS_REQ]),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_class(out_class),
    .out_msg  (out_msg),
    .pop_rsp  (q_pop[CLS_RSP]),
    .pop_req  (q_pop[CLS_REQ])
  );

  assign out_addr = out_msg[MSG_W-1:DATA_W];
  assign out_data = out_msg[DATA_W-1:0];
endmodule

// File: rtl/plink_checker.sv
module plink_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_class,
  input logic              in_ready_rsp,
  input logic              in_ready_req,
  input logic              out_valid,
  input logic              out_class,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              rsp_held_none
);
  assert_req_behind_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_class) |-> rsp_held_none);

  assert_rsp_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class) |-> in_ready_rsp);

  assert_accept_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class ? in_ready_rsp : in_ready_req)) |=> out_valid);

  assert_stall_keeps_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_rsp_held_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class && !out_ready) |=>
      (out_valid && out_class && $stable(out_addr) && $stable(out_data)));
endmodule

bind prio_msg_link plink_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_class     (in_class),
  .in_ready_rsp (in_ready_rsp),
  .in_ready_req (in_ready_req),
  .out_valid    (out_valid),
  .out_class    (out_class),
  .out_addr     (out_addr),
  .out_data     (out_data),
  .out_ready    (out_ready),
  .rsp_held_none(q_empty[1])
);

// File: tb/prio_msg_link_test.sv
module prio_msg_link_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int RSP_DEPTH = 4;
  localparam int REQ_DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_class = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready_rsp, in_ready_req;
  logic out_valid, out_class;
  logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data;
  logic out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W+DATA_W-1:0] exp_rsp [$];
  logic [ADDR_W+DATA_W-1:0] exp_req [$];

  always #10 clk = ~clk;

  prio_msg_link #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_DEPTH(RSP_DEPTH), .REQ_DEPTH(REQ_DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_addr(in_addr), .in_data(in_data), .in_ready_rsp(in_ready_rsp),
    .in_ready_req(in_ready_req), .out_valid(out_valid), .out_class(out_class),
    .out_addr(out_addr), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit cls, input int a, input int d, input bit rdy);
    logic [ADDR_W+DATA_W-1:0] e;
    @(negedge clk);
    if (exp_rsp.size() + exp_req.size() > 0)
      check(out_valid, "R7 out_valid with beats held", out_valid, 1);
    if (exp_rsp.size() > 0 && out_valid)
      check(out_class, "R3 response presented first", out_class, 1);
    if (out_valid && !out_class)
      check(exp_rsp.size() == 0, "R3 request while response held", exp_rsp.size(), 0);
    if (out_valid && rdy) begin
      if (out_class) begin
        if (exp_rsp.size() == 0) check(0, "R2 unexpected response", {out_addr, out_data}, 0);
        else begin
          e = exp_rsp.pop_front();
          check({out_addr, out_data} == e, "R4 response order", {out_addr, out_data}, e);
        end
      end else begin
        if (exp_req.size() == 0) check(0, "R2 unexpected request", {out_addr, out_data}, 0);
        else begin
          e = exp_req.pop_front();
          check({out_addr, out_data} == e, "R4 request order", {out_addr, out_data}, e);
        end
      end
    end
    out_ready = rdy;
    in_valid  = v;
    in_class  = cls;
    in_addr   = ADDR_W'(a);
    in_data   = DATA_W'(d);
    if (v && cls && in_ready_rsp) exp_rsp.push_back({ADDR_W'(a), DATA_W'(d)});
    if (v && !cls && in_ready_req) exp_req.push_back({ADDR_W'(a), DATA_W'(d)});
    @(posedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) begin
      if (exp_rsp.size() + exp_req.size() == 0) break;
      step(0, 0, 0, 0, 1);
    end
    step(0, 0, 0, 0, 1);
    @(negedge clk);
    check(exp_rsp.size() + exp_req.size() == 0, "R4 all beats delivered",
          exp_rsp.size() + exp_req.size(), 0);
    check(!out_valid, "R4 output idle after drain", out_valid, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a0;
    logic [DATA_W-1:0] d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready_rsp, "R1 in_ready_rsp after reset", in_ready_rsp, 1);
    check(in_ready_req, "R1 in_ready_req after reset", in_ready_req, 1);
    rst_n = 1'b1;
    @(posedge clk);

    // R2 R4: mixed stream with consumer always ready
    for (int i = 0; i < 12; i++) step(1, (i % 3) == 1, i + 16, 16'h1000 + i, 1);
    drain();

    // R3 R4: requests first, then responses, consumer stalled
    step(1, 0, 1, 16'hA001, 0);
    step(1, 0, 2, 16'hA002, 0);
    step(1, 1, 3, 16'hB003, 0);
    step(1, 1, 4, 16'hB004, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(out_class && out_addr == 8'd3, "R3 response preempts waiting request",
          {out_class, out_addr}, {1'b1, 8'd3});
    @(posedge clk);
    drain();

    // R4: same address, response then request
    step(1, 1, 8'h55, 16'hC001, 0);
    step(1, 0, 8'h55, 16'hC002, 0);
    drain();

    // R5: fill request queue, responses still accepted
    for (int i = 0; i < REQ_DEPTH; i++) step(1, 0, 32 + i, 16'hD000 + i, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(!in_ready_req, "R5 in_ready_req low when full", in_ready_req, 0);
    check(in_ready_rsp, "R5 in_ready_rsp stays high", in_ready_rsp, 1);
    @(posedge clk);
    step(1, 1, 8'h77, 16'hE001, 0);
    step(1, 0, 8'h78, 16'hE002, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(out_valid && out_class && out_data == 16'hE001, "R5 response accepted past full requests",
          out_data, 16'hE001);
    @(posedge clk);
    drain();

    // R6 R8: fill response queue with consumer stalled
    for (int i = 0; i < RSP_DEPTH; i++) step(1, 1, 64 + i, 16'hF000 + i, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(!in_ready_rsp, "R6 in_ready_rsp low when full", in_ready_rsp, 0);
    check(in_ready_req, "R6 in_ready_req unaffected", in_ready_req, 1);
    a0 = out_addr;
    d0 = out_data;
    @(posedge clk);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(out_valid && out_class && out_addr == a0 && out_data == d0,
          "R8 stalled response held", {out_addr, out_data}, {a0, d0});
    check(a0 == 8'd64 && d0 == 16'hF000, "R4 oldest response at head", {a0, d0}, {8'd64, 16'hF000});
    @(posedge clk);
    drain();

    // R2 R3 R7: alternating with intermittent consumer
    for (int i = 0; i < 16; i++) step((i % 4) != 3, (i % 2) == 0, 100 + i, 16'h2000 + i, (i % 3) != 0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule